// File: doc/BRIEF.md
# DMA Transfer Chaining Trigger Sequencer

This block walks one DMA channel through the transfer requests of a block and, for each request, decides whether a chain event goes to another channel. The channel is set up with an arrays-per-frame count, a frames-per-block count and a sync-mode select. In per-array mode each request moves one array, so a block needs arrays × frames requests. In per-frame mode each request moves a whole frame, so a block needs frames requests. Each request waits for an external sync event. It is then offered on a valid/ready handshake. A completion strobe comes back for every request, and completions arrive in issue order.

Two enables choose which requests raise a chain event. The final enable selects the last request of the block. The intermediate enable selects every other request. With both set, every request raises one. A completion-mode select sets when the event fires: when the request is accepted (early) or when its completion returns (normal). The event is a one-cycle pulse that carries a 6-bit target channel number. After the last completion of the block, a done pulse follows and the block restarts from its first request.

Top module: `chain_trig_seq`

## Requirements
- R1: With `sync_mode` = 0 (per-array), one block issues exactly `n_arrays` × `n_frames` accepted requests, and `req_last` is high only on the last of them.
- R2: With `sync_mode` = 1 (per-frame), one block issues exactly `n_frames` accepted requests, and `req_last` is high only on the last.
- R3: With only `chain_final_en` set, exactly one chain pulse fires per block, and it belongs to the last request.
- R4: With only `chain_mid_en` set, a chain pulse fires for every request of the block except the last (zero pulses when the block has a single request).
- R5: With both enables set, a chain pulse fires for every request of the block.
- R6: Every chain pulse carries `chain_ch` equal to `target_ch`.
- R7: With `early_cpl` = 1, a chain pulse is high during the cycle that follows a handshake (`req_valid` and `req_ready` both high), and at no other time.
- R8: With `early_cpl` = 0, a chain pulse is high during the cycle that follows an accepted `cpl_strobe`. No pulse fires at issue.
- R9: `req_valid` rises only in the cycle after a `sync_evt`. Once raised, it and `req_last` stay stable until `req_ready`. A `sync_evt` that arrives while a request is pending is dropped.
- R10: `done` is a one-cycle pulse in the cycle after the block's last completion. After it, the counts restart and the next block behaves the same way.
- R11: A `cpl_strobe` that arrives while no request is outstanding is ignored. It does not advance the completion count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_arrays | input | 8 | Arrays per frame (nonzero) |
| n_frames | input | 8 | Frames per block (nonzero) |
| sync_mode | input | 1 | 0 = one array per request, 1 = one frame per request |
| chain_final_en | input | 1 | Chain on the last request of the block |
| chain_mid_en | input | 1 | Chain on every request except the last |
| early_cpl | input | 1 | 1 = chain at issue, 0 = chain at completion |
| target_ch | input | 6 | Channel that chain events are aimed at |
| sync_evt | input | 1 | External sync event that releases one request |
| req_valid | output | 1 | Transfer request offered |
| req_ready | input | 1 | Transfer request taken |
| req_last | output | 1 | Offered request is the last one of the block |
| cpl_strobe | input | 1 | Completion of the oldest outstanding request |
| chain_pulse | output | 1 | One-cycle chain event |
| chain_ch | output | 6 | Target channel of the chain event |
| done | output | 1 | One-cycle pulse after the block's last completion |

## Verification
The hardest case to reach is telling early chaining apart from normal chaining. With a completion returned right after each issue, the two modes give identical pulse counts. The bench therefore issues every request of a block before it returns any completion. It counts pulses after the issue phase and again after the completion phase: in early mode all pulses must already be present, and in normal mode there must be none until completions flow. Dropped sync events and stray completions are reached by holding `req_ready` low while an extra sync arrives, and by strobing a completion before anything is outstanding. In both cases the later request and done counts must come out unchanged.

// File: rtl/chain_trig_pkg.sv
package chain_trig_pkg;
    localparam int CNT_W = 8;
    localparam int CH_W  = 6;
    localparam int TOT_W = 2 * CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [TOT_W-1:0] tot_t;
    typedef logic [CH_W-1:0]  ch_t;

    typedef enum logic {
        SYNC_ARRAY = 1'b0,
        SYNC_FRAME = 1'b1
    } sync_mode_e;

    typedef struct packed {
        logic fire;
        ch_t  ch;
    } chain_evt_t;

    function automatic tot_t block_reqs(input cnt_t arrays, input cnt_t frames,
                                        input sync_mode_e mode);
        tot_t prod;
        prod = tot_t'(arrays) * tot_t'(frames);
        return (mode == SYNC_FRAME) ? tot_t'(frames) : prod;
    endfunction

    function automatic logic chain_wanted(input logic is_last, input logic fin_en,
                                          input logic mid_en);
        return is_last ? fin_en : mid_en;
    endfunction
endpackage

// File: rtl/cct_issue.sv
module cct_issue
    import chain_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_evt,
    input  logic req_ready,
    input  tot_t total,
    input  logic clear,
    output logic req_valid,
    output logic req_last,
    output logic hs,
    output logic hs_last
);
    tot_t issued;

    assign req_last = (issued == total - tot_t'(1));
    assign hs       = req_valid && req_ready;
    assign hs_last  = hs && req_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            issued    <= '0;
            req_valid <= 1'b0;
        end else begin
            if (clear)
                issued <= '0;
            else if (hs)
                issued <= issued + tot_t'(1);

            if (hs)
                req_valid <= 1'b0;
            else if (sync_evt && !req_valid && !clear && (issued < total))
                req_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/cct_track.sv
module cct_track
    import chain_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hs,
    input  logic cpl_strobe,
    input  tot_t total,
    output logic cpl_ok,
    output logic cpl_last
);
    tot_t outstanding;
    tot_t completed;

    assign cpl_ok   = cpl_strobe && (outstanding != '0);
    assign cpl_last = cpl_ok && (completed == total - tot_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
            completed   <= '0;
        end else begin
            case ({hs, cpl_ok})
                2'b10:   outstanding <= outstanding + tot_t'(1);
                2'b01:   outstanding <= outstanding - tot_t'(1);
                default: outstanding <= outstanding;
            endcase
            if (cpl_last)
                completed <= '0;
            else if (cpl_ok)
                completed <= completed + tot_t'(1);
        end
    end
endmodule

// File: rtl/cct_chain.sv
module cct_chain
    import chain_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic early_cpl,
    input  logic fin_en,
    input  logic mid_en,
    input  logic hs,
    input  logic hs_last,
    input  logic cpl_ok,
    input  logic cpl_last,
    input  ch_t  target,
    output chain_evt_t evt,
    output logic done
);
    logic fire_d;

    always_comb begin
        if (early_cpl)
            fire_d = hs && chain_wanted(hs_last, fin_en, mid_en);
        else
            fire_d = cpl_ok && chain_wanted(cpl_last, fin_en, mid_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt  <= '0;
            done <= 1'b0;
        end else begin
            evt.fire <= fire_d;
            evt.ch   <= fire_d ? target : evt.ch;
            done     <= cpl_last;
        end
    end
endmodule

// File: rtl/chain_trig_seq.sv
module chain_trig_seq
    import chain_trig_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CNT_W-1:0] n_arrays,
    input  logic [CNT_W-1:0] n_frames,
    input  logic            sync_mode,
    input  logic            chain_final_en,
    input  logic            chain_mid_en,
    input  logic            early_cpl,
    input  logic [CH_W-1:0] target_ch,
    input  logic            sync_evt,
    output logic            req_valid,
    input  logic            req_ready,
    output logic            req_last,
    input  logic            cpl_strobe,
    output logic            chain_pulse,
    output logic [CH_W-1:0] chain_ch,
    output logic            done
);
    tot_t       total;
    logic       hs, hs_last, cpl_ok, cpl_last;
    chain_evt_t evt;

    assign total = block_reqs(n_arrays, n_frames, sync_mode_e'(sync_mode));

    cct_issue u_issue (
        .clk(clk), .rst(rst), .sync_evt(sync_evt), .req_ready(req_ready),
        .total(total), .clear(cpl_last), .req_valid(req_valid),
        .req_last(req_last), .hs(hs), .hs_last(hs_last)
    );

    cct_track u_track (
        .clk(clk), .rst(rst), .hs(hs), .cpl_strobe(cpl_strobe),
        .total(total), .cpl_ok(cpl_ok), .cpl_last(cpl_last)
    );

    cct_chain u_chain (
        .clk(clk), .rst(rst), .early_cpl(early_cpl), .fin_en(chain_final_en),
        .mid_en(chain_mid_en), .hs(hs), .hs_last(hs_last), .cpl_ok(cpl_ok),
        .cpl_last(cpl_last), .target(target_ch), .evt(evt), .done(done)
    );

    assign chain_pulse = evt.fire;
    assign chain_ch    = evt.ch;
endmodule

// File: rtl/chain_trig_seq_chk.sv
module chain_trig_seq_chk
    import chain_trig_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [CNT_W-1:0] n_arrays,
    input logic [CNT_W-1:0] n_frames,
    input logic            sync_mode,
    input logic            chain_final_en,
    input logic            chain_mid_en,
    input logic            early_cpl,
    input logic [CH_W-1:0] target_ch,
    input logic            sync_evt,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_last,
    input logic            cpl_strobe,
    input logic            chain_pulse,
    input logic [CH_W-1:0] chain_ch,
    input logic            done
);
    // R9: a request is raised only after a sync event
    a_r9_valid_after_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(sync_evt));

    // R9: a pending request holds until taken
    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_last)));

    // R6: chain pulse carries the target channel
    a_r6_target_channel: assert property (@(posedge clk) disable iff (rst)
        chain_pulse |-> (chain_ch == $past(target_ch)));

    // R7: early chaining follows a handshake
    a_r7_early_after_hs: assert property (@(posedge clk) disable iff (rst)
        (chain_pulse && $past(early_cpl)) |-> $past(req_valid && req_ready));

    // R8: normal chaining follows a completion
    a_r8_normal_after_cpl: assert property (@(posedge clk) disable iff (rst)
        (chain_pulse && !$past(early_cpl)) |-> $past(cpl_strobe));

    // R10: done follows a completion and lasts one cycle
    a_r10_done_after_cpl: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cpl_strobe));
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind chain_trig_seq chain_trig_seq_chk u_chk (.*);

// File: tb/chain_trig_seq_test.sv
module chain_trig_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] n_arrays = 8'd1, n_frames = 8'd1;
    logic       sync_mode = 1'b0, chain_final_en = 1'b0, chain_mid_en = 1'b0;
    logic       early_cpl = 1'b0;
    logic [5:0] target_ch = 6'd0;
    logic       sync_evt = 1'b0, req_ready = 1'b0, cpl_strobe = 1'b0;
    logic       req_valid, req_last, chain_pulse, done;
    logic [5:0] chain_ch;

    int checks = 0, errors = 0;
    int n_chain = 0, n_done = 0, n_hs = 0, last_idx = 0, n_last = 0, tim_err = 0, ch_err = 0;
    logic prev_hs = 1'b0, prev_cpl = 1'b0;

    always #5 clk = ~clk;

    chain_trig_seq uut (.*);

    always @(negedge clk) begin
        if (chain_pulse) begin
            n_chain++;
            if (chain_ch != target_ch) ch_err++;
            if (early_cpl ? !prev_hs : !prev_cpl) tim_err++;
        end
        if (done) n_done++;
        prev_hs  = req_valid && req_ready;
        prev_cpl = cpl_strobe;
        if (req_valid && req_ready) begin
            n_hs++;
            if (req_last) begin n_last++; last_idx = n_hs; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic run_block(input int na, input int nf, input bit ab, input bit fin,
                             input bit mid, input bit early, input int ch,
                             input bit slow_ready, input bit stray);
        int total, exp_chain;
        total = ab ? nf : na * nf;
        exp_chain = (fin ? 1 : 0) + (mid ? total - 1 : 0);
        n_arrays = 8'(na); n_frames = 8'(nf); sync_mode = ab;
        chain_final_en = fin; chain_mid_en = mid; early_cpl = early;
        target_ch = 6'(ch);
        step();
        n_chain = 0; n_done = 0; n_hs = 0; last_idx = 0; n_last = 0; tim_err = 0; ch_err = 0;
        if (stray) begin
            cpl_strobe = 1'b1; step(); cpl_strobe = 1'b0; step();
        end
        for (int i = 0; i < total; i++) begin
            sync_evt = 1'b1; step(); sync_evt = 1'b0;
            while (!req_valid) step();
            if (slow_ready) begin
                step(); sync_evt = 1'b1; step(); sync_evt = 1'b0; step();
            end
            req_ready = 1'b1; step(); req_ready = 1'b0; step();
        end
        // extra sync after the block is fully issued must not add a request
        sync_evt = 1'b1; step(); sync_evt = 1'b0; step(); step();
        check(ab ? "R2 request count" : "R1 request count", n_hs, total);
        check(ab ? "R2 last flag position" : "R1 last flag position", last_idx, total);
        check("R1 single last flag", n_last, 1);
        check(early ? "R7 chains at issue" : "R8 no chain at issue", n_chain,
              early ? exp_chain : 0);
        check("R10 no done before completions", n_done, 0);
        for (int i = 0; i < total; i++) begin
            cpl_strobe = 1'b1; step(); cpl_strobe = 1'b0; step();
        end
        step();
        if (fin && !mid)      check("R3 final only count", n_chain, exp_chain);
        else if (mid && !fin) check("R4 intermediate only count", n_chain, exp_chain);
        else                  check("R5 all requests chained", n_chain, exp_chain);
        check(early ? "R7 pulse timing" : "R8 pulse timing", tim_err, 0);
        check("R6 target channel", ch_err, 0);
        check("R10 one done per block", n_done, 1);
        if (stray) check("R11 stray completion ignored", n_done, 1);
        if (slow_ready) check("R9 sync while pending dropped", n_hs, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R9 reset req_valid", int'(req_valid), 0);
        check("R10 reset done", int'(done), 0);
        check("R7 reset chain_pulse", int'(chain_pulse), 0);
        run_block(4, 5, 1'b0, 1'b1, 1'b0, 1'b1, 30, 1'b0, 1'b0);
        run_block(4, 5, 1'b0, 1'b0, 1'b1, 1'b0, 17, 1'b0, 1'b0);
        run_block(4, 5, 1'b1, 1'b1, 1'b1, 1'b1, 63, 1'b1, 1'b0);
        run_block(4, 5, 1'b1, 1'b0, 1'b1, 1'b0, 5, 1'b0, 1'b0);
        run_block(2, 3, 1'b0, 1'b1, 1'b1, 1'b0, 42, 1'b0, 1'b1);
        run_block(3, 1, 1'b1, 1'b0, 1'b1, 1'b1, 9, 1'b0, 1'b0);
        run_block(4, 5, 1'b0, 1'b1, 1'b1, 1'b1, 30, 1'b1, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule